// File: doc/BRIEF.md
# Receive Buffer Allocation Controller

This block handles the receive path of an Ethernet controller that keeps frames in a shared packet memory. When the MAC signals that a frame has begun, the block asks the memory manager for a buffer and keeps the packet number it is given. It then copies bytes from the MAC receive FIFO into that buffer. An 11-bit address counter places each byte just past a small reserved header.

When the frame finishes, the block either hands the buffer to the host or returns it to the memory manager. It hands the buffer over by pushing the packet number into the host receive queue, and writes the final byte count into the header first. It returns the buffer when the destination address did not match, when the CRC was bad and bad frames are not accepted, or when the frame grew too long. Address filtering, CRC checking and the memory manager itself sit outside this block.

Top module: `rx_buf_alloc_ctrl`

## Requirements
- R1: A frame-start pulse seen while idle raises `mmu_alloc_req` in the next cycle. The request stays high until the memory manager answers with a grant or a failure.
- R2: After a grant, one byte is popped from the MAC FIFO in each cycle that the FIFO is not empty. The n-th byte (n from 0) is written to address HDR+n (HDR=2) of the granted packet.
- R3: An address-miss pulse during data transfer stops all further pops. It causes exactly one release of the granted packet number and no queue push.
- R4: A frame end with good CRC leads to two header writes, then one `rxq_push` carrying the granted packet number.
- R5: A frame end with bad CRC releases the buffer and pushes nothing while `cfg_accept_bad`=0. With `cfg_accept_bad`=1 the frame is delivered exactly as in R4.
- R6: When a 1533rd data byte is presented, that byte is not written. The buffer is released and `rx_abort` goes high, staying high until the next accepted frame start.
- R7: The header is written after the data. Address 0 receives count[7:0] and address 1 receives {5'b0, count[10:8]}, where count is the number of data bytes written.
- R8: An allocation failure returns the block to idle without popping the FIFO, and the next frame start is accepted.
- R9: When an address miss and a frame end arrive in the same cycle, the miss wins: the buffer is released and nothing is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_rx_start | input | 1 | Frame-start pulse from the MAC |
| mac_addr_miss | input | 1 | Pulse: destination address did not match |
| mac_frame_end | input | 1 | Pulse: frame complete |
| mac_crc_ok | input | 1 | CRC result, valid with `mac_frame_end` |
| cfg_accept_bad | input | 1 | Deliver frames with bad CRC |
| mac_fifo_empty | input | 1 | MAC receive FIFO is empty |
| mac_fifo_data | input | 8 | Head byte of the MAC FIFO (show-ahead) |
| mac_fifo_pop | output | 1 | Consume the head byte |
| mmu_alloc_req | output | 1 | Buffer allocation request |
| mmu_alloc_ack | input | 1 | Allocation granted |
| mmu_alloc_fail | input | 1 | Allocation refused |
| mmu_pkt_num | input | 6 | Granted packet number |
| mmu_release | output | 1 | Release pulse |
| mmu_release_num | output | 6 | Packet number to release |
| mem_we | output | 1 | Buffer write strobe |
| mem_pkt | output | 6 | Packet number being written |
| mem_addr | output | 11 | Byte address inside the packet |
| mem_wdata | output | 8 | Byte written |
| rxq_push | output | 1 | Push into the host receive queue |
| rxq_num | output | 6 | Packet number pushed |
| rx_abort | output | 1 | Oversize-frame abort status |

## Verification
An address miss can arrive in the same cycle as a frame end. Here the release path and the delivery path compete for one decision. The bench provokes this by draining a short frame and then pulsing both inputs on one negative edge. The scoreboard then accepts only a single release of the granted number, with no header writes and no queue push. A second overlap comes from a frame end pulsed in the same cycle as the final pop. That case must still produce the full, correct count in the header.

// File: rtl/rx_buf_alloc_ctrl.sv
module rx_buf_alloc_ctrl #(
  parameter int AW      = 11,
  parameter int PNW     = 6,
  parameter int MAX_LEN = 1532,
  parameter int HDR     = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mac_rx_start,
  input  logic           mac_addr_miss,
  input  logic           mac_frame_end,
  input  logic           mac_crc_ok,
  input  logic           cfg_accept_bad,
  input  logic           mac_fifo_empty,
  input  logic [7:0]     mac_fifo_data,
  output logic           mac_fifo_pop,
  output logic           mmu_alloc_req,
  input  logic           mmu_alloc_ack,
  input  logic           mmu_alloc_fail,
  input  logic [PNW-1:0] mmu_pkt_num,
  output logic           mmu_release,
  output logic [PNW-1:0] mmu_release_num,
  output logic           mem_we,
  output logic [PNW-1:0] mem_pkt,
  output logic [AW-1:0]  mem_addr,
  output logic [7:0]     mem_wdata,
  output logic           rxq_push,
  output logic [PNW-1:0] rxq_num,
  output logic           rx_abort
);
  localparam logic [AW-1:0] LIM  = AW'(MAX_LEN);
  localparam logic [AW-1:0] BASE = AW'(HDR);

  typedef enum logic [2:0] {S_IDLE, S_ALLOC, S_DATA, S_HLO, S_HHI, S_PUSH, S_REL} st_t;
  st_t st;
  logic [AW-1:0]  cnt;
  logic [PNW-1:0] pkt;
  logic end_seen, crc_seen;

  wire in_data = (st == S_DATA);
  wire over    = (cnt == LIM);
  wire ended   = end_seen | mac_frame_end;
  wire crc_ok  = end_seen ? crc_seen : mac_crc_ok;

  assign mac_fifo_pop    = in_data && !mac_addr_miss && !mac_fifo_empty && !over;
  assign mmu_alloc_req   = (st == S_ALLOC);
  assign mmu_release     = (st == S_REL);
  assign mmu_release_num = pkt;
  assign rxq_push        = (st == S_PUSH);
  assign rxq_num         = pkt;
  assign mem_pkt         = pkt;
  assign mem_we          = mac_fifo_pop || st == S_HLO || st == S_HHI;
  assign mem_addr        = (st == S_HLO) ? '0 : (st == S_HHI) ? AW'(1) : cnt + BASE;
  assign mem_wdata       = (st == S_HLO) ? cnt[7:0] : (st == S_HHI) ? 8'(cnt >> 8) : mac_fifo_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; pkt <= '0;
      end_seen <= 1'b0; crc_seen <= 1'b0; rx_abort <= 1'b0;
    end else begin
      if ((st == S_ALLOC || in_data) && mac_frame_end && !end_seen) begin
        end_seen <= 1'b1;
        crc_seen <= mac_crc_ok;
      end
      if (mac_fifo_pop) cnt <= cnt + 1'b1;
      unique case (st)
        S_IDLE: if (mac_rx_start) begin
          st <= S_ALLOC; cnt <= '0; end_seen <= 1'b0; crc_seen <= 1'b0; rx_abort <= 1'b0;
        end
        S_ALLOC:
          if (mmu_alloc_ack) begin st <= S_DATA; pkt <= mmu_pkt_num; end
          else if (mmu_alloc_fail) st <= S_IDLE;
        S_DATA:
          if (mac_addr_miss) st <= S_REL;
          else if (!mac_fifo_empty) begin
            if (over) begin st <= S_REL; rx_abort <= 1'b1; end
          end else if (ended) st <= (crc_ok || cfg_accept_bad) ? S_HLO : S_REL;
        S_HLO:  st <= S_HHI;
        S_HHI:  st <= S_PUSH;
        S_PUSH: st <= S_IDLE;
        S_REL:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_req_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && mac_rx_start) |=> mmu_alloc_req);
  a_r1_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mmu_alloc_req && !mmu_alloc_ack && !mmu_alloc_fail) |=> mmu_alloc_req);
  a_r2_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    mac_fifo_pop |-> !mac_fifo_empty);
  a_r3_miss_stops_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && mac_addr_miss) |=> (mmu_release && !mac_fifo_pop));
  a_r5_release_or_push: assert property (@(posedge clk) disable iff (!rst_n)
    !(mmu_release && rxq_push));
  a_r6_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_abort) |-> mmu_release);
  a_r8_fail_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mmu_alloc_req && mmu_alloc_fail && !mmu_alloc_ack) |=> (!mmu_alloc_req && !mac_fifo_pop));
endmodule

// File: tb/rx_buf_alloc_ctrl_tb_top.sv
module rx_buf_alloc_ctrl_tb_top;
  localparam int PER = 10;
  localparam logic [1:0] K_WR = 2'd0, K_REL = 2'd1, K_PUSH = 2'd2;

  logic clk = 0, rst_n = 0;
  logic mac_rx_start = 0, mac_addr_miss = 0, mac_frame_end = 0, mac_crc_ok = 0, cfg_accept_bad = 0;
  logic mac_fifo_empty = 1;
  logic [7:0] mac_fifo_data = 0;
  logic mac_fifo_pop, mmu_alloc_req, mmu_release, mem_we, rxq_push, rx_abort;
  logic mmu_alloc_ack = 0, mmu_alloc_fail = 0;
  logic [5:0] mmu_pkt_num = 0, mmu_release_num, mem_pkt, rxq_num;
  logic [10:0] mem_addr;
  logic [7:0] mem_wdata;

  always #(PER/2) clk = ~clk;

  rx_buf_alloc_ctrl dut_i (.*);

  int checks = 0, fails = 0;
  logic [7:0] fq[$];
  logic [26:0] expq[$];
  string tagq[$];
  logic pop_s = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic expect_item(input logic [1:0] k, input logic [5:0] pn, input logic [10:0] a,
                             input logic [7:0] d, input string tag);
    expq.push_back({k, pn, a, d}); tagq.push_back(tag);
  endtask

  task automatic observe(input logic [26:0] item);
    if (expq.size() == 0) chk(0, "unexpected output", item, 0);
    else begin
      logic [26:0] e; string t;
      e = expq.pop_front(); t = tagq.pop_front();
      chk(item == e, t, item, e);
    end
  endtask

  always @(negedge clk) begin
    pop_s <= mac_fifo_pop;
    if (rst_n) begin
      if (mem_we)      observe({K_WR, mem_pkt, mem_addr, mem_wdata});
      if (mmu_release) observe({K_REL, mmu_release_num, 11'd0, 8'd0});
      if (rxq_push)    observe({K_PUSH, rxq_num, 11'd0, 8'd0});
    end
  end

  always @(posedge clk) begin
    if (pop_s && fq.size() > 0) void'(fq.pop_front());
    mac_fifo_empty <= (fq.size() == 0);
    mac_fifo_data  <= (fq.size() > 0) ? fq[0] : 8'h00;
  end

  task automatic start_alloc(input logic [5:0] pn, input bit fail);
    @(negedge clk) mac_rx_start = 1;
    @(negedge clk) mac_rx_start = 0;
    chk(mmu_alloc_req === 1'b1, "R1 request after start", mmu_alloc_req, 1);
    @(negedge clk);
    chk(mmu_alloc_req === 1'b1, "R1 request held", mmu_alloc_req, 1);
    if (fail) mmu_alloc_fail = 1; else begin mmu_alloc_ack = 1; mmu_pkt_num = pn; end
    @(negedge clk) begin mmu_alloc_ack = 0; mmu_alloc_fail = 0; end
  endtask

  task automatic feed(input logic [5:0] pn, input int n, input int seed, input int expw, input string tag);
    for (int i = 0; i < n; i++) begin
      fq.push_back(8'(seed + i));
      if (i < expw) expect_item(K_WR, pn, 11'(2 + i), 8'(seed + i), tag);
    end
  endtask

  task automatic drain();
    while (fq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic end_pulse(input bit crc, input bit miss);
    mac_frame_end = 1; mac_crc_ok = crc; mac_addr_miss = miss;
    @(negedge clk) begin mac_frame_end = 0; mac_crc_ok = 0; mac_addr_miss = 0; end
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_deliver(input logic [5:0] pn, input int n, input string tag);
    expect_item(K_WR, pn, 11'd0, 8'(n), {tag, " R7 low count"});
    expect_item(K_WR, pn, 11'd1, 8'(n >> 8), {tag, " R7 high count"});
    expect_item(K_PUSH, pn, 11'd0, 8'd0, {tag, " push"});
  endtask

  task automatic q_empty(input string tag);
    chk(expq.size() == 0, tag, expq.size(), 0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    chk(!mmu_alloc_req && !mac_fifo_pop && !mem_we && !mmu_release && !rxq_push && !rx_abort,
        "reset state idle", {mmu_alloc_req, mac_fifo_pop, mem_we, mmu_release, rxq_push, rx_abort}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R4 R7: good frame
    start_alloc(6'd3, 0);
    feed(6'd3, 5, 8'h10, 5, "R2 data write");
    expect_deliver(6'd3, 5, "R4 good crc");
    drain(); end_pulse(1, 0);
    q_empty("R4 all items seen");

    // R5: bad crc rejected
    start_alloc(6'd9, 0);
    feed(6'd9, 4, 8'h40, 4, "R2 data write");
    expect_item(K_REL, 6'd9, 0, 0, "R5 bad crc release");
    drain(); end_pulse(0, 0);
    q_empty("R5 no push on bad crc");

    // R5: bad crc accepted
    cfg_accept_bad = 1;
    start_alloc(6'd12, 0);
    feed(6'd12, 3, 8'h70, 3, "R2 data write");
    expect_deliver(6'd12, 3, "R5 accept bad");
    drain(); end_pulse(0, 0);
    cfg_accept_bad = 0;
    q_empty("R5 accepted frame delivered");

    // R3: address miss
    start_alloc(6'd20, 0);
    feed(6'd20, 4, 8'h90, 4, "R2 data write");
    expect_item(K_REL, 6'd20, 0, 0, "R3 miss release");
    drain();
    mac_addr_miss = 1; @(negedge clk) mac_addr_miss = 0;
    fq.push_back(8'hEE);
    repeat (5) @(negedge clk);
    chk(fq.size() == 1, "R3 no pop after miss", fq.size(), 1);
    fq.delete();
    repeat (2) @(negedge clk);
    q_empty("R3 no push after miss");

    // R8: allocation failure
    fq.push_back(8'h01); fq.push_back(8'h02);
    start_alloc(6'd5, 1);
    repeat (5) @(negedge clk);
    chk(fq.size() == 2, "R8 no pop after fail", fq.size(), 2);
    chk(!mmu_alloc_req, "R8 back to idle", mmu_alloc_req, 0);
    fq.delete();
    repeat (2) @(negedge clk);
    start_alloc(6'd6, 0);
    feed(6'd6, 2, 8'hA0, 2, "R8 next frame data");
    expect_deliver(6'd6, 2, "R8 next frame");
    drain(); end_pulse(1, 0);
    q_empty("R8 next frame complete");

    // R9: miss and end in the same cycle
    start_alloc(6'd33, 0);
    feed(6'd33, 3, 8'hC0, 3, "R2 data write");
    expect_item(K_REL, 6'd33, 0, 0, "R9 miss beats end");
    drain(); end_pulse(1, 1);
    q_empty("R9 no push");

    // R7: frame end in the same cycle as the last pop
    start_alloc(6'd40, 0);
    feed(6'd40, 1, 8'h55, 1, "R2 data write");
    expect_deliver(6'd40, 1, "R7 end with last pop");
    @(negedge clk);
    while (!(fq.size() == 1 && !mac_fifo_empty)) @(negedge clk);
    end_pulse(1, 0);
    q_empty("R7 single byte frame");

    // R6: oversize abort
    start_alloc(6'd50, 0);
    feed(6'd50, 1533, 0, 1532, "R6 data write");
    expect_item(K_REL, 6'd50, 0, 0, "R6 abort release");
    while (fq.size() > 1) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(rx_abort === 1'b1, "R6 abort flag", rx_abort, 1);
    chk(fq.size() == 1, "R6 extra byte not taken", fq.size(), 1);
    fq.delete();
    repeat (2) @(negedge clk);
    q_empty("R6 no push");
    chk(rx_abort === 1'b1, "R6 abort flag held", rx_abort, 1);
    start_alloc(6'd51, 0);
    chk(rx_abort === 1'b0, "R6 abort cleared on start", rx_abort, 0);
    feed(6'd51, 2, 8'h30, 2, "R2 data write");
    expect_deliver(6'd51, 2, "R4 after abort");
    drain(); end_pulse(1, 0);
    q_empty("R4 after abort complete");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule